// File: doc/BRIEF.md
# Secure Interrupt Flag Controller

This block keeps the interrupt status flags of seven transfer channels. Each channel reports three hardware events, half-way, complete and error, as one-cycle strobes. Each strobe sets a sticky event flag, and any event also sets the channel's summary (global) flag. Software reads all flags through one 32-bit status word and removes them by writing ones to a status-clear word that uses the same bit layout. Each channel drives one interrupt line, built from its flags and three per-channel enables. A per-channel lock output tells the channel's control logic that its enable bit may not be set while the error flag stands.

Every channel carries a secure attribute and a privileged attribute, and every register access carries the same two attributes. A status read returns zero in the nibble of any channel the access is not entitled to see. A clear that targets such a channel is dropped. A dropped clear, or a non-secure write of 1 to a secure-only configuration bit elsewhere in the channel, counts as a violation. A violation raises a one-cycle illegal-access pulse.

The pulse comes from a two-state machine. `GATE_IDLE` is the reset state and keeps the pulse low. A cycle with a violation moves the machine to `GATE_ALARM`, where the pulse is high. From `GATE_ALARM` the machine returns to `GATE_IDLE` after a cycle with no violation, and it stays in `GATE_ALARM` if the next violation follows at once.

Top module: `chan_irq_flags`

## Requirements
- R1: After reset every flag, `rd_data`, `irq`, `en_lock` and `ill_pulse` are zero.
- R2: Channel c (0..6) owns status bits 4c..4c+3, with bit 4c the global flag, 4c+1 complete, 4c+2 half and 4c+3 error; bits 31:28 always read zero. `rd_data` is registered and loads in the cycle `rd_en` is high.
- R3: Writing 1 to clear bit 4c (global) clears all four flags of channel c.
- R4: Writing 1 to an individual clear bit (4c+1..4c+3) clears that flag, and clears the global flag only if neither of the other two event flags stays set.
- R5: A clear write with 0 in a bit position leaves that flag unchanged.
- R6: A read with `acc_sec`=0 returns zero for channels with `chan_sec`=1, and a read with `acc_priv`=0 returns zero for channels with `chan_priv`=1.
- R7: A clear aimed at a secure channel needs `acc_sec`=1, and one aimed at a privileged channel needs `acc_priv`=1; otherwise that channel's flags stay unchanged, while permitted channels in the same write are still cleared.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: A dropped clear (R7) makes `ill_pulse` high for the cycle after the write, and `ill_pulse` is low after any cycle with no violation.
- R10: `en_lock[c]` is high exactly while channel c's error flag is set.
- R11: `irq[c]` = (half & `ie_half[c]`) | (complete & `ie_done[c]`) | (error & `ie_err[c]`) for channel c.
- R12: `cfg_ok` is high only when `cfg_wr` is high with `acc_sec`=1; `cfg_wr` with `acc_sec`=0 gives `cfg_ok`=0 and raises `ill_pulse` in the next cycle.
- R13: Event strobes set flags whatever the channel's secure and privileged attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_half | input | 7 | Per-channel half-way event strobe |
| evt_done | input | 7 | Per-channel complete event strobe |
| evt_err | input | 7 | Per-channel error event strobe |
| chan_sec | input | 7 | Channel is secure |
| chan_priv | input | 7 | Channel is privileged |
| ie_half | input | 7 | Half-way interrupt enable |
| ie_done | input | 7 | Complete interrupt enable |
| ie_err | input | 7 | Error interrupt enable |
| acc_sec | input | 1 | Current access is secure |
| acc_priv | input | 1 | Current access is privileged |
| clr_wr | input | 1 | Write strobe for the status-clear word |
| clr_data | input | 32 | Status-clear word, one clear bit per flag |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 32 | Filtered status word, registered |
| cfg_wr | input | 1 | Write of 1 to a secure-only configuration bit |
| cfg_ok | output | 1 | That configuration write may take effect |
| irq | output | 7 | Per-channel interrupt |
| en_lock | output | 7 | Per-channel block on setting the enable bit |
| ill_pulse | output | 1 | Illegal-access pulse |

## Verification
Two things can land on the same flag in one cycle: a hardware event strobe and a software clear. The bench causes this by raising a channel's error strobe and writing that channel's error clear bit on the same clock edge. It then expects the flag and the lock to read as set. A second overlap puts a permitted clear and a forbidden clear in one write. The bench checks that the permitted channel clears, the forbidden one stays and the illegal-access pulse fires, all from the same edge.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int NCH_DEF    = 7;
    localparam int DATA_W_DEF = 32;
    localparam int NIB_W      = 4;
    // Field order inside a channel nibble: the clear word decodes the same way.
    localparam int BIT_GLB  = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_HALF = 2;
    localparam int BIT_ERR  = 3;

    typedef enum logic [0:0] {
        GATE_IDLE  = 1'b0,
        GATE_ALARM = 1'b1
    } gate_st_e;
endpackage

// File: rtl/irqf_access_gate.sv
module irqf_access_gate
    import irqf_pkg::*;
#(
    parameter int NCH = NCH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_sec,
    input  logic           acc_priv,
    input  logic [NCH-1:0] chan_sec,
    input  logic [NCH-1:0] chan_priv,
    input  logic           clr_wr,
    input  logic [NCH*NIB_W-1:0] clr_bits,
    input  logic           cfg_wr,
    output logic [NCH-1:0] vis,
    output logic [NCH-1:0] clr_glb,
    output logic [NCH-1:0] clr_done,
    output logic [NCH-1:0] clr_half,
    output logic [NCH-1:0] clr_err,
    output logic           cfg_ok,
    output logic           ill_pulse
);
    gate_st_e       state_q, state_d;
    logic [NCH-1:0] chan_bad;
    logic           violation;

    // Per-channel entitlement and clear filtering.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NIB_W-1:0] req;
        assign vis[c]      = (~chan_sec[c] | acc_sec) & (~chan_priv[c] | acc_priv);
        assign req         = clr_bits[c*NIB_W +: NIB_W] & {NIB_W{clr_wr}};
        assign clr_glb[c]  = req[BIT_GLB]  & vis[c];
        assign clr_done[c] = req[BIT_DONE] & vis[c];
        assign clr_half[c] = req[BIT_HALF] & vis[c];
        assign clr_err[c]  = req[BIT_ERR]  & vis[c];
        assign chan_bad[c] = (|req) & ~vis[c];
    end

    assign cfg_ok    = cfg_wr & acc_sec;
    assign violation = (|chan_bad) | (cfg_wr & ~acc_sec);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE:  if (violation)  state_d = GATE_ALARM;
            GATE_ALARM: if (!violation) state_d = GATE_IDLE;
            default:                    state_d = GATE_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        ill_pulse = 1'b0;
        unique case (state_q)
            GATE_IDLE:  ill_pulse = 1'b0;
            GATE_ALARM: ill_pulse = 1'b1;
            default:    ill_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqf_chan_flags.sv
module irqf_chan_flags
    import irqf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_half,
    input  logic             set_done,
    input  logic             set_err,
    input  logic             clr_glb,
    input  logic             clr_done,
    input  logic             clr_half,
    input  logic             clr_err,
    input  logic             ie_half,
    input  logic             ie_done,
    input  logic             ie_err,
    output logic [NIB_W-1:0] nib,
    output logic             irq,
    output logic             lock
);
    logic half_q, done_q, err_q, glb_q;
    logic half_d, done_d, err_d, glb_d;

    // A set in the same cycle as a clear wins.
    always_comb begin
        half_d = set_half | (half_q & ~(clr_half | clr_glb));
        done_d = set_done | (done_q & ~(clr_done | clr_glb));
        err_d  = set_err  | (err_q  & ~(clr_err  | clr_glb));
        if (set_half | set_done | set_err)
            glb_d = 1'b1;
        else if (clr_glb)
            glb_d = 1'b0;
        else if (clr_half | clr_done | clr_err)
            glb_d = half_d | done_d | err_d;
        else
            glb_d = glb_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            glb_q  <= 1'b0;
        end else begin
            half_q <= half_d;
            done_q <= done_d;
            err_q  <= err_d;
            glb_q  <= glb_d;
        end
    end

    always_comb begin
        nib           = '0;
        nib[BIT_GLB]  = glb_q;
        nib[BIT_DONE] = done_q;
        nib[BIT_HALF] = half_q;
        nib[BIT_ERR]  = err_q;
    end

    assign irq  = (half_q & ie_half) | (done_q & ie_done) | (err_q & ie_err);
    assign lock = err_q;
endmodule

// File: rtl/irqf_read_port.sv
module irqf_read_port
    import irqf_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [NCH-1:0]       vis,
    input  logic [NCH*NIB_W-1:0] flags,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int USED_W = NCH * NIB_W;

    logic [DATA_W-1:0] masked;

    always_comb begin
        masked = '0;
        for (int c = 0; c < NCH; c++)
            masked[c*NIB_W +: NIB_W] = flags[c*NIB_W +: NIB_W] & {NIB_W{vis[c]}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= masked;
    end

    if (USED_W > DATA_W) begin : g_bad_cfg
        initial $fatal(1, "channel count does not fit the status word");
    end
endmodule

// File: rtl/chan_irq_flags.sv
module chan_irq_flags
    import irqf_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_half,
    input  logic [NCH-1:0]    evt_done,
    input  logic [NCH-1:0]    evt_err,
    input  logic [NCH-1:0]    chan_sec,
    input  logic [NCH-1:0]    chan_priv,
    input  logic [NCH-1:0]    ie_half,
    input  logic [NCH-1:0]    ie_done,
    input  logic [NCH-1:0]    ie_err,
    input  logic              acc_sec,
    input  logic              acc_priv,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_wr,
    output logic              cfg_ok,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    en_lock,
    output logic              ill_pulse
);
    localparam int USED_W = NCH * NIB_W;

    logic [NCH-1:0]    vis, c_glb, c_done, c_half, c_err;
    logic [USED_W-1:0] flags;

    if (DATA_W > USED_W) begin : g_rsvd
        logic unused_rsvd;
        assign unused_rsvd = ^clr_data[DATA_W-1:USED_W];
    end

    irqf_access_gate #(.NCH(NCH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_sec   (acc_sec),
        .acc_priv  (acc_priv),
        .chan_sec  (chan_sec),
        .chan_priv (chan_priv),
        .clr_wr    (clr_wr),
        .clr_bits  (clr_data[USED_W-1:0]),
        .cfg_wr    (cfg_wr),
        .vis       (vis),
        .clr_glb   (c_glb),
        .clr_done  (c_done),
        .clr_half  (c_half),
        .clr_err   (c_err),
        .cfg_ok    (cfg_ok),
        .ill_pulse (ill_pulse)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irqf_chan_flags u_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_half (evt_half[c]),
            .set_done (evt_done[c]),
            .set_err  (evt_err[c]),
            .clr_glb  (c_glb[c]),
            .clr_done (c_done[c]),
            .clr_half (c_half[c]),
            .clr_err  (c_err[c]),
            .ie_half  (ie_half[c]),
            .ie_done  (ie_done[c]),
            .ie_err   (ie_err[c]),
            .nib      (flags[c*NIB_W +: NIB_W]),
            .irq      (irq[c]),
            .lock     (en_lock[c])
        );
    end

    irqf_read_port #(.NCH(NCH), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .vis     (vis),
        .flags   (flags),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int NCH    = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    evt_err,
    input logic [NCH-1:0]    ie_half,
    input logic [NCH-1:0]    ie_done,
    input logic [NCH-1:0]    ie_err,
    input logic              acc_sec,
    input logic              clr_wr,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] rd_data,
    input logic [NCH-1:0]    irq,
    input logic [NCH-1:0]    en_lock,
    input logic              ill_pulse
);
    localparam int USED_W = NCH * 4;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:USED_W] == '0); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_err != '0) |=> ((en_lock & $past(evt_err)) == $past(evt_err))); // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((en_lock & $past(en_lock)) == $past(en_lock))); // R10
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ill_pulse) |-> $past(clr_wr || cfg_wr)); // R9
    AST_QUIET_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !cfg_wr) |=> !ill_pulse); // R9
    AST_CFG_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !acc_sec) |=> ill_pulse); // R12
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~(ie_half | ie_done | ie_err)) == '0); // R11
endmodule

bind chan_irq_flags irqf_checker #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_err   (evt_err),
    .ie_half   (ie_half),
    .ie_done   (ie_done),
    .ie_err    (ie_err),
    .acc_sec   (acc_sec),
    .clr_wr    (clr_wr),
    .cfg_wr    (cfg_wr),
    .rd_data   (rd_data),
    .irq       (irq),
    .en_lock   (en_lock),
    .ill_pulse (ill_pulse)
);

// File: tb/chan_irq_flags_bench.sv
`timescale 1ns/100ps
module chan_irq_flags_bench;
    localparam int NCH = 7;
    localparam int SEL_RD = 0, SEL_IRQ = 1, SEL_LOCK = 2, SEL_ILL = 3, SEL_CFG = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] evt_half, evt_done, evt_err, chan_sec, chan_priv;
    logic [NCH-1:0] ie_half, ie_done, ie_err;
    logic acc_sec, acc_priv, clr_wr, rd_en, cfg_wr;
    logic [31:0] clr_data;
    logic [31:0] rd_data;
    logic cfg_ok, ill_pulse;
    logic [NCH-1:0] irq, en_lock;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    string       q_req[$];
    int          q_sel[$];
    logic [31:0] q_exp[$];

    always #2 clk = ~clk;

    chan_irq_flags u_chan_irq_flags (
        .clk(clk), .rst_n(rst_n),
        .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err),
        .chan_sec(chan_sec), .chan_priv(chan_priv),
        .ie_half(ie_half), .ie_done(ie_done), .ie_err(ie_err),
        .acc_sec(acc_sec), .acc_priv(acc_priv),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .cfg_wr(cfg_wr), .cfg_ok(cfg_ok),
        .irq(irq), .en_lock(en_lock), .ill_pulse(ill_pulse)
    );

    // Monitor: compares queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q_sel.size() > 0) begin
                string       r;
                int          s;
                logic [31:0] e, a;
                r = q_req.pop_front();
                s = q_sel.pop_front();
                e = q_exp.pop_front();
                case (s)
                    SEL_RD:   a = rd_data;
                    SEL_IRQ:  a = {25'd0, irq};
                    SEL_LOCK: a = {25'd0, en_lock};
                    SEL_ILL:  a = {31'd0, ill_pulse};
                    default:  a = {31'd0, cfg_ok};
                endcase
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
                end
            end
        end
    end

    task automatic expect_item(input string r, input int s, input logic [31:0] e);
        q_req.push_back(r);
        q_sel.push_back(s);
        q_exp.push_back(e);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
        evt_half = '0; evt_done = '0; evt_err = '0;
        clr_wr = 1'b0; clr_data = '0; rd_en = 1'b0; cfg_wr = 1'b0;
        acc_sec = 1'b1; acc_priv = 1'b1;
    endtask

    task automatic do_read(input string r, input logic s, input logic p, input logic [31:0] e);
        rd_en = 1'b1; acc_sec = s; acc_priv = p;
        @(posedge clk);
        expect_item(r, SEL_RD, e);
        settle();
    endtask

    task automatic do_clear(input logic s, input logic p, input logic [31:0] d,
                            input string r, input logic ill_exp);
        clr_wr = 1'b1; clr_data = d; acc_sec = s; acc_priv = p;
        @(posedge clk);
        expect_item(r, SEL_ILL, {31'd0, ill_exp});
        settle();
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        evt_half = '0; evt_done = '0; evt_err = '0;
        chan_sec = 7'b000_0100;   // channel 2 secure
        chan_priv = 7'b100_0000;  // channel 6 privileged
        ie_half = '0; ie_done = '0; ie_err = '0;
        acc_sec = 1'b1; acc_priv = 1'b1;
        clr_wr = 1'b0; clr_data = '0; rd_en = 1'b0; cfg_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R1: reset state
        expect_item("R1 irq", SEL_IRQ, 32'h0);
        expect_item("R1 lock", SEL_LOCK, 32'h0);
        expect_item("R1 ill", SEL_ILL, 32'h0);
        do_read("R1 status", 1, 1, 32'h0);

        // R2 / R13: layout, sets on secure and privileged channels
        evt_half[0] = 1'b1; evt_done[2] = 1'b1; evt_err[6] = 1'b1;
        @(posedge clk);
        settle();
        expect_item("R10 lock after error", SEL_LOCK, 32'h40);
        do_read("R2 R13 layout", 1, 1, 32'h0900_0305);

        // R6: read filtering
        do_read("R6 nonsecure read", 0, 1, 32'h0900_0005);
        do_read("R6 unprivileged read", 1, 0, 32'h0000_0305);
        do_read("R6 nonsecure unprivileged", 0, 0, 32'h0000_0005);

        // R3: global clear of channel 0
        do_clear(1, 1, 32'h0000_0001, "R3 no alarm", 1'b0);
        do_read("R3 global clear", 1, 1, 32'h0900_0300);

        // R5: zero write
        do_clear(1, 1, 32'h0000_0000, "R5 no alarm", 1'b0);
        do_read("R5 zero write", 1, 1, 32'h0900_0300);

        // R4: individual clears on channel 1
        evt_half[1] = 1'b1; evt_done[1] = 1'b1;
        @(posedge clk);
        settle();
        do_read("R4 two flags", 1, 1, 32'h0900_0370);
        do_clear(1, 1, 32'h0000_0020, "R4 no alarm", 1'b0);
        do_read("R4 global kept", 1, 1, 32'h0900_0350);
        do_clear(1, 1, 32'h0000_0040, "R4 no alarm", 1'b0);
        do_read("R4 global dropped", 1, 1, 32'h0900_0300);

        // R7 / R9: forbidden clears
        do_clear(0, 1, 32'h0000_0100, "R9 nonsecure clear alarm", 1'b1);
        expect_item("R9 pulse ends", SEL_ILL, 32'h0);
        do_read("R7 secure flags kept", 1, 1, 32'h0900_0300);
        do_clear(1, 0, 32'h0800_0000, "R9 unprivileged clear alarm", 1'b1);
        do_read("R7 privileged flags kept", 1, 1, 32'h0900_0300);
        do_clear(1, 1, 32'h0900_0100, "R7 entitled clear quiet", 1'b0);
        do_read("R7 entitled clear", 1, 1, 32'h0000_0000);
        expect_item("R10 lock released", SEL_LOCK, 32'h0);
        @(posedge clk);
        settle();

        // R8: set beats clear on channel 3 error
        evt_err[3] = 1'b1;
        clr_wr = 1'b1; clr_data = 32'h0000_8000;
        @(posedge clk);
        expect_item("R8 lock", SEL_LOCK, 32'h08);
        settle();
        do_read("R8 set wins", 1, 1, 32'h0000_9000);

        // R11: interrupt enables
        ie_err = 7'h08;
        @(posedge clk);
        expect_item("R11 error irq", SEL_IRQ, 32'h08);
        settle();
        ie_err = 7'h00; ie_half = 7'h7F; ie_done = 7'h7F;
        @(posedge clk);
        expect_item("R11 other enables", SEL_IRQ, 32'h0);
        settle();

        // R12: secure-only configuration write
        cfg_wr = 1'b1; acc_sec = 1'b0;
        @(posedge clk);
        expect_item("R12 nonsecure refused", SEL_CFG, 32'h0);
        expect_item("R12 alarm", SEL_ILL, 32'h1);
        settle();
        cfg_wr = 1'b1; acc_sec = 1'b1;
        @(posedge clk);
        expect_item("R12 secure allowed", SEL_CFG, 32'h1);
        expect_item("R12 no alarm", SEL_ILL, 32'h0);
        settle();

        // R7: mixed clear, channel 3 allowed, channel 2 refused
        evt_done[2] = 1'b1;
        @(posedge clk);
        settle();
        do_clear(0, 1, 32'h0000_8100, "R7 mixed alarm", 1'b1);
        do_read("R7 mixed result", 1, 1, 32'h0000_0300);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule